// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Bus Decoder

This block sits on the device side of an asynchronous parallel host bus. It samples the host's active-low select, read-enable and write-enable pins together with the address and data pins. It turns each host access into one clean request of a single cycle in the internal clock domain. Read requests go out at the start of an access and write requests at its end, so the register file behind the block sees simple synchronous strobes.

A configuration bit picks how the pins are read. In two-strobe mode, select only qualifies the access. The read-enable pin then times a read and the write-enable pin times a write. In one-strobe mode, select is the only strobe and each assertion of it is one access. The read-enable pin becomes a direction level (high for read, low for write), and the write-enable pin is unused. This suits hosts that can time select for every access, and it frees one pin. A change of the configuration bit is adopted only while select is deasserted.

Read data comes back through a data-out bus and an output-enable signal. A pad ring can use these to drive a shared bus.

Top module: `hostbus_decoder`

## Requirements
- R1: In two-strobe mode (`cfg_single_pin`=0), with `bus_cs_n` low, a falling `bus_oe_n` produces exactly one `rd_req` pulse, with `req_addr` equal to the address on the pins.
- R2: In two-strobe mode, with `bus_cs_n` low, a low pulse on `bus_we_n` produces exactly one `wr_req` pulse after `bus_we_n` returns high. `req_addr` and `wr_data` carry the address and data that were on the pins during the strobe.
- R3: In two-strobe mode, toggling `bus_oe_n` or `bus_we_n` while `bus_cs_n` is high produces no request and leaves `bus_data_oe` low.
- R4: In one-strobe mode (`cfg_single_pin`=1), each low period of `bus_cs_n` with `bus_oe_n` high produces exactly one `rd_req` pulse.
- R5: In one-strobe mode, each low period of `bus_cs_n` with `bus_oe_n` low produces exactly one `wr_req` pulse after `bus_cs_n` rises, carrying the captured address and data. `bus_we_n` has no effect in this mode.
- R6: `bus_data_oe` rises only in the cycle after an `rd_req` pulse. It stays high, with `bus_data_out` stable and equal to the data addressed, until the read strobe ends. Outside a read it is low.
- R7: A change of `cfg_single_pin` while `bus_cs_n` is low does not alter the decoding of the access in progress. The new mode applies once `bus_cs_n` has been high.
- R8: `rd_req` and `wr_req` are each one cycle wide and are never high together.
- R9: During and right after reset, `rd_req`, `wr_req` and `bus_data_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_single_pin | input | 1 | 0: two-strobe mode, 1: one-strobe mode |
| bus_cs_n | input | 1 | Host select pin, active low |
| bus_oe_n | input | 1 | Host read-enable pin or direction level |
| bus_we_n | input | 1 | Host write-enable pin, active low |
| bus_addr | input | AW | Host address pins |
| bus_data_in | input | DW | Data from host pins |
| bus_data_out | output | DW | Read data toward the host pins |
| bus_data_oe | output | 1 | Drive enable for the host data pins |
| rd_req | output | 1 | One-cycle read request |
| wr_req | output | 1 | One-cycle write request |
| req_addr | output | AW | Address of the current request |
| wr_data | output | DW | Write data of the current write request |
| rd_data | input | DW | Read data returned for `req_addr` in the `rd_req` cycle |

## Verification
The bench writes distinct values to several addresses in each mode and reads them back. A wrong address capture or a lost write therefore shows up as a readback mismatch, not only as a missing pulse. Strobe toggles with select high separate proper gating from decoding based on the strobe alone. Write-enable toggles in one-strobe mode confirm that the pin is ignored. A mode flip in the middle of a write exposes a decoder that switches modes too early: with the direction pin high, that would turn the write into a read.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef struct packed {
        logic single;   // adopted mode
        logic rd_prev;  // read strobe active last cycle
        logic wr_prev;  // write strobe active last cycle
        logic rd_req;
        logic wr_req;
    } dec_state_t;

    localparam dec_state_t DEC_RESET = '{single: 1'b0, rd_prev: 1'b0,
                                         wr_prev: 1'b0, rd_req: 1'b0,
                                         wr_req: 1'b0};

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int          W      = 8,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hbd_strobe_decode.sv
module hbd_strobe_decode
    import hbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_single,
    input  logic cs_n_s,
    input  logic oe_n_s,
    input  logic we_n_s,
    output logic rd_act,
    output logic wr_act,
    output logic rd_start,
    output logic rd_req,
    output logic wr_req
);
    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.single) begin
            rd_act = !cs_n_s && oe_n_s;
            wr_act = !cs_n_s && !oe_n_s;
        end else begin
            rd_act = !cs_n_s && !oe_n_s;
            wr_act = !cs_n_s && !we_n_s;
        end
        rd_start     = rd_act && !st_q.rd_prev;
        st_d.rd_req  = rd_start;
        st_d.wr_req  = !wr_act && st_q.wr_prev;
        st_d.rd_prev = rd_act;
        st_d.wr_prev = wr_act;
        // mode is adopted only between accesses
        if (cs_n_s) st_d.single = cfg_single;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_RESET;
        else        st_q <= st_d;
    end

    assign rd_req = st_q.rd_req;
    assign wr_req = st_q.wr_req;
endmodule

// File: rtl/hbd_datapath.sv
module hbd_datapath #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic          rd_start,
    input  logic          rd_req,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] bus_data_out,
    output logic          bus_data_oe
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          drive;
    } dp_state_t;

    dp_state_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (rd_start || wr_act) dp_d.addr  = addr_s;
        if (wr_act)             dp_d.wdata = data_s;
        if (rd_req)             dp_d.rdata = rd_data;
        dp_d.drive = rd_req || (dp_q.drive && rd_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign req_addr     = dp_q.addr;
    assign wr_data      = dp_q.wdata;
    assign bus_data_oe  = dp_q.drive;
    assign bus_data_out = dp_q.drive ? dp_q.rdata : '0;
endmodule

// File: rtl/hostbus_decoder.sv
module hostbus_decoder #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_single_pin,
    input  logic          bus_cs_n,
    input  logic          bus_oe_n,
    input  logic          bus_we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data_in,
    output logic [DW-1:0] bus_data_out,
    output logic          bus_data_oe,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_data
);
    localparam int SW = 3 + AW + DW;
    localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(AW+DW){1'b0}}};

    logic [SW-1:0] pins_s;
    logic          cs_n_s, oe_n_s, we_n_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          rd_act, wr_act, rd_start;

    hbd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_cs_n, bus_oe_n, bus_we_n, bus_addr, bus_data_in}),
        .dout (pins_s)
    );

    assign {cs_n_s, oe_n_s, we_n_s, addr_s, data_s} = pins_s;

    hbd_strobe_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_single(cfg_single_pin),
        .cs_n_s    (cs_n_s),
        .oe_n_s    (oe_n_s),
        .we_n_s    (we_n_s),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .rd_start  (rd_start),
        .rd_req    (rd_req),
        .wr_req    (wr_req)
    );

    hbd_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .rd_act      (rd_act),
        .wr_act      (wr_act),
        .rd_start    (rd_start),
        .rd_req      (rd_req),
        .rd_data     (rd_data),
        .req_addr    (req_addr),
        .wr_data     (wr_data),
        .bus_data_out(bus_data_out),
        .bus_data_oe (bus_data_oe)
    );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          wr_req,
    input logic          bus_data_oe,
    input logic [DW-1:0] bus_data_out
);
    // R8
    a_r8_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R8
    a_r8_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R8
    a_r8_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);
    // R6
    a_r6_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_data_oe) |-> $past(rd_req));
    // R6
    a_r6_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));
    // R6: no request during a read drive other than the one that started it
    a_r6_no_write_while_drive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !wr_req);
endmodule

bind hostbus_decoder hbd_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .bus_data_oe (bus_data_oe),
    .bus_data_out(bus_data_out)
);

// File: tb/sim_hostbus_decoder.sv
`timescale 1ns/1ps
module sim_hostbus_decoder;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_single_pin = 1'b0;
    logic          bus_cs_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data_in = '0;
    logic [DW-1:0] bus_data_out, wr_data, rd_data;
    logic          bus_data_oe, rd_req, wr_req;
    logic [AW-1:0] req_addr;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [DW-1:0] regs [2**AW];

    always #2.5 clk = ~clk;

    hostbus_decoder #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_single_pin(cfg_single_pin),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_data_in(bus_data_in),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // simple register array behind the decoder
    assign rd_data = regs[req_addr];
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req) rd_cnt++;
            if (wr_req) begin
                wr_cnt++;
                regs[req_addr] = wr_data;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(1);
        chk("R9 rd_req in reset", rd_req, 0);
        chk("R9 oe in reset", bus_data_oe, 0);
        rst_n = 1'b1;
        idle(3);
        chk("R9 rd_req after reset", rd_req, 0);
        chk("R9 wr_req after reset", wr_req, 0);
        chk("R9 oe after reset", bus_data_oe, 0);
    endtask

    task automatic dual_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int r0 = rd_cnt, w0 = wr_cnt;
        bus_addr = a; bus_data_in = d; bus_cs_n = 0;
        idle(2); bus_we_n = 0;
        idle(4); bus_we_n = 1;
        idle(2); bus_cs_n = 1; bus_data_in = ~d;
        idle(4);
        chk("R2 one write pulse", wr_cnt - w0, 1);
        chk("R2 no read pulse", rd_cnt - r0, 0);
        chk("R2 stored data", regs[a], d);
    endtask

    task automatic dual_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int r0 = rd_cnt, w0 = wr_cnt;
        bus_addr = a; bus_cs_n = 0;
        idle(2); bus_oe_n = 0;
        idle(6);
        chk("R6 drive during read", bus_data_oe, 1);
        chk("R1 readback", bus_data_out, exp);
        bus_oe_n = 1;
        idle(2); bus_cs_n = 1;
        idle(4);
        chk("R6 drive off after read", bus_data_oe, 0);
        chk("R1 one read pulse", rd_cnt - r0, 1);
        chk("R1 no write pulse", wr_cnt - w0, 0);
    endtask

    task automatic cs_gate;
        int r0 = rd_cnt, w0 = wr_cnt;
        for (int i = 0; i < 4; i++) begin
            bus_oe_n = 0; idle(4); bus_oe_n = 1; idle(2);
            bus_we_n = 0; idle(4); bus_we_n = 1; idle(2);
        end
        chk("R3 no read without select", rd_cnt - r0, 0);
        chk("R3 no write without select", wr_cnt - w0, 0);
        chk("R3 no drive without select", bus_data_oe, 0);
    endtask

    task automatic single_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int r0 = rd_cnt, w0 = wr_cnt;
        bus_addr = a; bus_data_in = d; bus_oe_n = 0;
        idle(2); bus_cs_n = 0;
        idle(2); bus_we_n = 0;
        idle(2); bus_we_n = 1;
        idle(2); bus_cs_n = 1;
        idle(4); bus_oe_n = 1;
        idle(2);
        chk("R5 one write pulse", wr_cnt - w0, 1);
        chk("R5 no read pulse", rd_cnt - r0, 0);
        chk("R5 stored data", regs[a], d);
    endtask

    task automatic single_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                               input logic we_level);
        int r0 = rd_cnt, w0 = wr_cnt;
        bus_addr = a; bus_oe_n = 1; bus_we_n = we_level;
        idle(2); bus_cs_n = 0;
        idle(6);
        chk("R6 drive during single read", bus_data_oe, 1);
        chk("R4 readback", bus_data_out, exp);
        bus_cs_n = 1;
        idle(4); bus_we_n = 1;
        chk("R6 drive off", bus_data_oe, 0);
        chk("R4 one read pulse", rd_cnt - r0, 1);
        chk("R5 write pin ignored", wr_cnt - w0, 0);
    endtask

    task automatic mode_flip_mid_write;
        int r0 = rd_cnt, w0 = wr_cnt;
        cfg_single_pin = 0; idle(3);
        bus_addr = 8'h5A; bus_data_in = 16'hC3C3; bus_oe_n = 1;
        bus_cs_n = 0; idle(2);
        bus_we_n = 0; idle(3);
        cfg_single_pin = 1; idle(4);
        bus_we_n = 1; idle(2);
        bus_cs_n = 1; idle(4);
        chk("R7 write kept", wr_cnt - w0, 1);
        chk("R7 no read from flip", rd_cnt - r0, 0);
        chk("R7 data stored", regs[8'h5A], 16'hC3C3);
        single_read(8'h5A, 16'hC3C3, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) regs[i] = '0;
        t_reset;
        dual_write(8'h12, 16'hBEEF);
        dual_write(8'h34, 16'h1234);
        dual_write(8'hFF, 16'hA5A5);
        dual_read(8'h12, 16'hBEEF);
        dual_read(8'h34, 16'h1234);
        dual_read(8'hFF, 16'hA5A5);
        cs_gate;
        cfg_single_pin = 1; idle(4);
        single_write(8'h01, 16'h0F0F);
        single_write(8'h80, 16'h7E81);
        single_read(8'h01, 16'h0F0F, 1'b1);
        single_read(8'h80, 16'h7E81, 1'b0);  // R5: write pin low, still a read
        single_read(8'h12, 16'hBEEF, 1'b0);
        mode_flip_mid_write;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule